// File: doc/BRIEF.md
# Lockup Watchdog Timer

This block guards a processor against software lockups. It counts cycles of a slow always-on clock, nominally 32 kHz, against a period chosen by a 4-bit prescale code. If software does not restart the count before the period runs out, the block raises a one-cycle chip-reset request. The period ranges from 256 cycles (about 8 ms) to 524288 cycles (about 16.4 s). A sticky cause flag records that the watchdog produced the request. That flag survives the ordinary reset the request triggers, so software can tell this reset apart from other resets after it restarts.

Software reaches the block through a simple register strobe interface. It can write an enable bit and the prescale code, write a restart command, and read or clear the cause flag. Sideband inputs carry the CPU power and debug state. Sleep, deep sleep and a debugger halt freeze the count, and doze does not. A debugger halt only pauses the count: when the halt ends, counting resumes from where it stopped. When sleep or deep sleep ends, the block re-arms with the enable set, the longest period selected and the count at zero. The ordinary reset and the power-on reset do the same.

Top module: `lockup_watchdog`

## Requirements
- R1: After `rst` or `por`, the control register reads enable=1 and code=11 (value 0x1B), `reset_req` is low, and the count starts from zero.
- R2: With prescale code n (0 to 11), `reset_req` rises exactly 2^(8+n) counting clock edges after the edge that last restarted the count.
- R3: A write of any data to address 1 restarts the count from zero; a restart on the same edge that would have expired suppresses that request.
- R4: The control register at address 0 holds the code in bits [3:0] and the enable in bit 4; a written code above 11 is stored and read back as 11.
- R5: A control write that changes the code restarts the count, so the new period runs in full from that write.
- R6: While the enable is 0, no request is raised; writing enable=1 starts the count from zero.
- R7: No counting edge occurs while `sleep_i`, `deep_sleep_i` or `dbg_halt_i` is high; `doze_i` has no effect on counting.
- R8: When `dbg_halt_i` falls, counting continues from the held value, so the request is delayed by exactly the number of halted edges.
- R9: When sleep or deep sleep ends (the OR of both falls), the block re-arms: enable=1, code=11, count at zero.
- R10: The cause flag (address 2, bit 0) becomes 1 together with `reset_req`, is kept through `rst`, is cleared by `por` or by writing 1 to bit 0 at address 2, and is unchanged by writing 0 there.
- R11: `reset_req` is high for one clock cycle per expiry.
- R12: Reads of address 1 and address 3 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow counting clock |
| rst | input | 1 | Synchronous active-high reset; keeps the cause flag |
| por | input | 1 | Synchronous active-high power-on reset; clears everything |
| sleep_i | input | 1 | CPU in sleep |
| deep_sleep_i | input | 1 | CPU in deep sleep |
| doze_i | input | 1 | CPU in doze (counting continues) |
| dbg_halt_i | input | 1 | Debugger has halted the CPU |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 restart, 2 cause |
| reg_wdata | input | 5 | Register write data |
| reg_rdata | output | 5 | Register read data, combinational from `reg_addr` |
| reset_req | output | 1 | One-cycle chip-reset request on expiry |
| wd_status | output | 1 | Cause flag: last reset came from this watchdog |

## Verification
The expiry timing is tried with several prescale codes from a restart write, and each one separates a correct shift of the period from an off-by-one or a wrong exponent. A restart placed exactly on the expiring edge shows whether the restart wins over the expiry. A code change part-way through a period shows whether the period restarts or carries on from the old count. Halts, doze and sleep windows inserted into a running period separate a count that holds from one that keeps running or one that restarts. The cause flag is carried through the ordinary reset, a write of 0 and a write of 1, and then through power-on reset, which separates the three ways it could be wrongly cleared.

// File: rtl/lwd_pkg.sv
package lwd_pkg;

    localparam int unsigned LWD_CODE_W   = 4;
    localparam int unsigned LWD_BASE_EXP = 8;
    localparam int unsigned LWD_MAX_CODE = 11;

    // register select on the strobe interface
    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_KICK  = 2'd1,
        SEL_CAUSE = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    // CPU state as seen by the counter
    typedef struct packed {
        logic freeze;
        logic wake;
    } gate_t;

    // reasons for starting the count again from zero
    typedef struct packed {
        logic kick;
        logic recode;
        logic wake;
        logic off;
    } restart_t;

    function automatic int unsigned lwd_sat(input int unsigned v, input int unsigned hi);
        return (v > hi) ? hi : v;
    endfunction

endpackage

// File: rtl/lwd_gate.sv
module lwd_gate
    import lwd_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  sleep_i,
    input  logic  deep_sleep_i,
    input  logic  dbg_halt_i,
    output gate_t gate
);

    logic asleep;
    logic asleep_q;

    assign asleep = sleep_i | deep_sleep_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            asleep_q <= 1'b0;
        end else begin
            asleep_q <= asleep;
        end
    end

    always_comb begin
        gate.freeze = asleep | dbg_halt_i;
        gate.wake   = asleep_q & ~asleep;
    end

    // R9: a wake-up is only reported on the cycle the CPU has left sleep
    p_wake_awake_r9: assert property (@(posedge clk) disable iff (rst)
        gate.wake |-> (!sleep_i && !deep_sleep_i));

endmodule

// File: rtl/lwd_regs.sv
module lwd_regs
    import lwd_pkg::*;
#(
    parameter  int unsigned CODE_W   = LWD_CODE_W,
    parameter  int unsigned MAX_CODE = LWD_MAX_CODE,
    localparam int unsigned DATA_W   = CODE_W + 1
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              por,
    input  logic              we,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wake,
    input  logic              hit,
    output logic              en,
    output logic [CODE_W-1:0] code,
    output restart_t          why,
    output logic              status,
    output logic [DATA_W-1:0] rdata
);

    typedef struct packed {
        logic              en;
        logic [CODE_W-1:0] code;
    } ctrl_t;

    localparam logic [CODE_W-1:0] CODE_TOP = CODE_W'(MAX_CODE);
    localparam ctrl_t CTRL_ARM = '{en: 1'b1, code: CODE_TOP};

    reg_sel_e sel;
    ctrl_t    ctrl_q;
    ctrl_t    ctrl_wr;
    logic     wr_ctrl;
    logic     wr_kick;
    logic     wr_clear;
    logic     status_q;

    always_comb begin
        sel          = reg_sel_e'(addr);
        wr_ctrl      = we && (sel == SEL_CTRL);
        wr_kick      = we && (sel == SEL_KICK);
        wr_clear     = we && (sel == SEL_CAUSE) && wdata[0];
        ctrl_wr.en   = wdata[CODE_W];
        ctrl_wr.code = CODE_W'(lwd_sat(32'(wdata[CODE_W-1:0]), MAX_CODE));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_ARM;
        end else if (wake) begin
            ctrl_q <= CTRL_ARM;
        end else if (wr_ctrl) begin
            ctrl_q <= ctrl_wr;
        end
    end

    // the cause flag ignores the ordinary reset on purpose
    always_ff @(posedge clk) begin
        if (por) begin
            status_q <= 1'b0;
        end else if (hit) begin
            status_q <= 1'b1;
        end else if (wr_clear) begin
            status_q <= 1'b0;
        end
    end

    always_comb begin
        why.kick   = wr_kick;
        why.recode = wr_ctrl && (ctrl_wr.code != ctrl_q.code);
        why.wake   = wake;
        why.off    = !ctrl_q.en;
    end

    always_comb begin
        unique case (sel)
            SEL_CTRL:  rdata = ctrl_q;
            SEL_CAUSE: rdata = DATA_W'(status_q);
            default:   rdata = '0;
        endcase
    end

    assign en     = ctrl_q.en;
    assign code   = ctrl_q.code;
    assign status = status_q;

    // R1: every reset re-arms enable and the longest period
    p_reset_arms_r1: assert property (@(posedge clk) disable iff (por)
        rst |=> (en && code == CODE_TOP));

    // R4: stored code never exceeds the top code
    p_code_sat_r4: assert property (@(posedge clk) disable iff (rst)
        code <= CODE_TOP);

    // R9: wake-up re-arms the control state
    p_wake_reinit_r9: assert property (@(posedge clk) disable iff (rst)
        wake |=> (en && code == CODE_TOP));

    // R10: an expiry always leaves the flag set
    p_status_set_r10: assert property (@(posedge clk) disable iff (por)
        hit |=> status);

    // R10: the flag only drops on a write of 1 to the cause register
    p_status_sticky_r10: assert property (@(posedge clk) disable iff (por)
        (status && !(we && addr == 2'd2 && wdata[0])) |=> status);

endmodule

// File: rtl/lwd_counter.sv
module lwd_counter
    import lwd_pkg::*;
#(
    parameter  int unsigned CODE_W   = LWD_CODE_W,
    parameter  int unsigned BASE_EXP = LWD_BASE_EXP,
    parameter  int unsigned MAX_CODE = LWD_MAX_CODE,
    localparam int unsigned CNT_W    = BASE_EXP + MAX_CODE
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [CODE_W-1:0] code,
    input  logic              freeze,
    input  logic              clear,
    input  logic              doze,
    output logic              hit,
    output logic              reset_req
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last;
    logic             run;
    logic             req_q;

    // period is 2^(BASE_EXP+code); at the top code the shift wraps to zero
    // and the subtraction yields all ones, which is the right terminal value
    always_comb begin
        last = (CNT_W'(1) << (BASE_EXP + 32'(code))) - CNT_W'(1);
        run  = en && !freeze;
        hit  = run && !clear && (cnt_q == last);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            req_q <= 1'b0;
        end else begin
            req_q <= hit;
            if (clear || hit) begin
                cnt_q <= '0;
            end else if (run) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    assign reset_req = req_q;

    // R11: the request never lasts two cycles
    p_req_single_r11: assert property (@(posedge clk) disable iff (rst)
        req_q |=> !req_q);

    // R2: a request follows the terminal count
    p_req_terminal_r2: assert property (@(posedge clk) disable iff (rst)
        req_q |-> ($past(cnt_q) == $past(last)));

    // R7: a frozen count holds its value
    p_freeze_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (freeze && !clear) |=> (cnt_q == $past(cnt_q)));

    // R7: doze does not stop the count
    p_doze_counts_r7: assert property (@(posedge clk) disable iff (rst)
        (doze && run && !clear && cnt_q != last) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

endmodule

// File: rtl/lockup_watchdog.sv
module lockup_watchdog
    import lwd_pkg::*;
#(
    parameter  int unsigned CODE_W   = LWD_CODE_W,
    parameter  int unsigned BASE_EXP = LWD_BASE_EXP,
    parameter  int unsigned MAX_CODE = LWD_MAX_CODE,
    localparam int unsigned DATA_W   = CODE_W + 1
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              por,
    input  logic              sleep_i,
    input  logic              deep_sleep_i,
    input  logic              doze_i,
    input  logic              dbg_halt_i,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              reset_req,
    output logic              wd_status
);

    logic              rst_any;
    gate_t             gate;
    restart_t          why;
    logic              en;
    logic [CODE_W-1:0] code;
    logic              hit;
    logic              clear;

    assign rst_any = rst | por;
    assign clear   = |why;

    lwd_gate u_gate (
        .clk          (clk),
        .rst          (rst_any),
        .sleep_i      (sleep_i),
        .deep_sleep_i (deep_sleep_i),
        .dbg_halt_i   (dbg_halt_i),
        .gate         (gate)
    );

    lwd_regs #(
        .CODE_W   (CODE_W),
        .MAX_CODE (MAX_CODE)
    ) u_regs (
        .clk    (clk),
        .rst    (rst_any),
        .por    (por),
        .we     (reg_we),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .wake   (gate.wake),
        .hit    (hit),
        .en     (en),
        .code   (code),
        .why    (why),
        .status (wd_status),
        .rdata  (reg_rdata)
    );

    lwd_counter #(
        .CODE_W   (CODE_W),
        .BASE_EXP (BASE_EXP),
        .MAX_CODE (MAX_CODE)
    ) u_cnt (
        .clk       (clk),
        .rst       (rst_any),
        .en        (en),
        .code      (code),
        .freeze    (gate.freeze),
        .clear     (clear),
        .doze      (doze_i),
        .hit       (hit),
        .reset_req (reset_req)
    );

    // R6: a disabled watchdog raises no request
    p_off_quiet_r6: assert property (@(posedge clk) disable iff (rst_any)
        !en |=> !reset_req);

endmodule

// File: tb/lockup_watchdog_tb.sv
module lockup_watchdog_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b0;
    logic       por = 1'b1;
    logic       sleep_i = 1'b0;
    logic       deep_sleep_i = 1'b0;
    logic       doze_i = 1'b0;
    logic       dbg_halt_i = 1'b0;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [4:0] reg_wdata = 5'd0;
    logic [4:0] reg_rdata;
    logic       reset_req;
    logic       wd_status;

    always #10 clk = ~clk;

    lockup_watchdog u_dut (
        .clk          (clk),
        .rst          (rst),
        .por          (por),
        .sleep_i      (sleep_i),
        .deep_sleep_i (deep_sleep_i),
        .doze_i       (doze_i),
        .dbg_halt_i   (dbg_halt_i),
        .reg_we       (reg_we),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .reset_req    (reset_req),
        .wd_status    (wd_status)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_bad = 0;
    int exp_q[$];
    int req_seen = 0;
    bit mon_on = 1'b0;
    logic prev_req = 1'b0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    // monitor: pops the next expected request cycle and compares
    always @(negedge clk) begin
        if (mon_on) begin
            if (reset_req && prev_req)
                check(1'b0, "R11 request wider than one cycle", 2, 1);
            if (reset_req && !prev_req) begin
                req_seen++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2 unexpected request at cycle", cyc, -1);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    check(cyc == e, "R2 request cycle", cyc, e);
                end
                check(wd_status == 1'b1, "R10 flag set with request", int'(wd_status), 1);
            end
            prev_req = reset_req;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // drive at a falling edge; the write lands on the next rising edge
    task automatic wr(input logic [1:0] a, input logic [4:0] d);
        reg_we    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        reg_addr = a;
        #1;
        v = int'(reg_rdata);
    endtask

    task automatic wait_until(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        idle(2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R2 watchdog expired actual=%0d expected=finish", cyc);
        summary();
        $finish;
    end

    initial begin
        int v;
        int e;
        int seen;
        idle(3);
        por = 1'b0;
        mon_on = 1'b1;

        // R1: state after power-on reset
        rd(2'd0, v); check(v == 'h1B, "R1 control after por", v, 'h1B);
        rd(2'd2, v); check(v == 0, "R10 flag after por", v, 0);
        check(reset_req == 1'b0, "R1 request low after por", int'(reset_req), 0);

        // R12: unused addresses read zero
        rd(2'd1, v); check(v == 0, "R12 restart address reads 0", v, 0);
        rd(2'd3, v); check(v == 0, "R12 spare address reads 0", v, 0);

        // R2: code 0 -> 256 edges
        wr(2'd0, 5'h10); e = cyc; exp_q.push_back(e + 256); drain();
        rd(2'd2, v); check(v == 1, "R10 flag readable after expiry", v, 1);

        // R10: write 0 keeps, rst keeps, write 1 clears
        wr(2'd2, 5'h00); rd(2'd2, v); check(v == 1, "R10 write 0 keeps flag", v, 1);
        rst = 1'b1; idle(1); rst = 1'b0;
        rd(2'd2, v); check(v == 1, "R10 flag kept through rst", v, 1);
        rd(2'd0, v); check(v == 'h1B, "R1 control after rst", v, 'h1B);
        wr(2'd2, 5'h01); rd(2'd2, v); check(v == 0, "R10 write 1 clears flag", v, 0);

        // R2: code 1 -> 512, code 3 -> 2048, code 5 -> 8192
        wr(2'd0, 5'h11); e = cyc; exp_q.push_back(e + 512); drain();
        wr(2'd0, 5'h13); e = cyc; exp_q.push_back(e + 2048); drain();
        wr(2'd0, 5'h15); e = cyc; exp_q.push_back(e + 8192); drain();

        // R3: restart mid-period, then on the expiring edge itself
        wr(2'd0, 5'h10); e = cyc;
        wait_until(e + 200);
        wr(2'd1, 5'h00); e = cyc;
        wait_until(e + 255);
        wr(2'd1, 5'h07); e = cyc;
        exp_q.push_back(e + 256); drain();

        // R5: code change restarts the period
        wr(2'd0, 5'h10); e = cyc;
        wait_until(e + 100);
        wr(2'd0, 5'h11); e = cyc; exp_q.push_back(e + 512); drain();

        // R4: code above 11 saturates
        wr(2'd0, 5'h1F); rd(2'd0, v); check(v == 'h1B, "R4 code 15 stored as 11", v, 'h1B);

        // R6: disabled watchdog stays quiet, re-enable starts from zero
        wr(2'd0, 5'h00); seen = req_seen; idle(700);
        check(req_seen == seen, "R6 no request while disabled", req_seen - seen, 0);
        wr(2'd0, 5'h10); e = cyc; exp_q.push_back(e + 256); drain();

        // R7/R8: debugger halt pauses; doze does not
        wr(2'd1, 5'h00); e = cyc;
        wait_until(e + 50);
        dbg_halt_i = 1'b1; idle(30); dbg_halt_i = 1'b0;
        doze_i = 1'b1; idle(40); doze_i = 1'b0;
        exp_q.push_back(e + 256 + 30); drain();

        // R9/R7: sleep freezes then re-arms with longest period
        wr(2'd1, 5'h00); e = cyc;
        wait_until(e + 100);
        sleep_i = 1'b1; idle(20); sleep_i = 1'b0; idle(2);
        rd(2'd0, v); check(v == 'h1B, "R9 control after sleep exit", v, 'h1B);
        seen = req_seen; wait_until(e + 600);
        check(req_seen == seen, "R9 old period dropped after sleep", req_seen - seen, 0);

        // R9: deep sleep exit, then period checked again
        wr(2'd0, 5'h10); e = cyc;
        wait_until(e + 100);
        deep_sleep_i = 1'b1; idle(20); deep_sleep_i = 1'b0; idle(2);
        rd(2'd0, v); check(v == 'h1B, "R9 control after deep sleep exit", v, 'h1B);
        seen = req_seen; wait_until(e + 600);
        check(req_seen == seen, "R9 no request after deep sleep re-arm", req_seen - seen, 0);
        wr(2'd0, 5'h10); e = cyc; exp_q.push_back(e + 256); drain();

        // R10: power-on reset clears the flag
        rd(2'd2, v); check(v == 1, "R10 flag set before por", v, 1);
        por = 1'b1; idle(1); por = 1'b0;
        rd(2'd2, v); check(v == 0, "R10 por clears flag", v, 0);

        check(exp_q.size() == 0, "R2 all expected requests seen", exp_q.size(), 0);
        summary();
        $finish;
    end

endmodule